// File: doc/BRIEF.md
# Serial Port Interrupt Event Register

This block holds the pending-event flags of a four-channel serial peripheral interface controller in one 32-bit memory-mapped word. The transmit and receive logic of each channel delivers single-cycle event pulses: transmit register empty, transmit underflow and receive full. Channel 0 also reports a receive overflow. A separate pulse reports that a FIFO-backed transfer has moved its programmed word count. Each pulse sets a sticky flag. Software reads the word and writes ones to acknowledge flags.

A channel's pulses are only recorded while that channel is enabled. An underflow is only recorded after the channel's transmit register has been written at least once since the channel was last enabled, so a freshly started channel with nothing queued raises no spurious underflow. When the receive FIFO is in use, the receive-full pulse carries the almost-full condition; the register stores whatever pulse it is given. In system-test mode, every read returns zero while flag state is kept.

Top module: `spi_irq_status_reg`

## Requirements
- R1: After reset every flag is 0 and a read of the register returns 0.
- R2: For channel n (0..3), bit 4n is transmit empty, bit 4n+1 is transmit underflow and bit 4n+2 is receive full. Bit 3 is the channel 0 receive overflow. Bits 7, 11, 15, 16 and 31..18 always read 0.
- R3: A register write clears each flag whose write-data bit is 1 and leaves the flags whose write-data bit is 0 unchanged.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A channel's empty, underflow, full and overflow pulses set flags only in cycles where that channel's enable is high. Pulses on a disabled channel change nothing.
- R6: A channel's underflow pulse sets bit 4n+1 only if a transmit load pulse arrived in an earlier cycle while the channel was enabled, with no disabled cycle since. A load in the same cycle as the underflow does not qualify it.
- R7: The word-count pulse sets bit 17 whatever the channel enables are.
- R8: While test mode is high a read returns 0. Flags still set and clear, and they become visible once test mode drops.
- R9: A read strobe at the register address returns the flags as they stood at that clock edge on rd_data one cycle later. In every other cycle rd_data is 0, and a write at another address clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | System-test mode, masks reads |
| ch_enable | input | 4 | Per-channel enable |
| tx_load | input | 4 | Per-channel transmit register write pulse |
| tx_empty_ev | input | 4 | Per-channel transmit empty pulse |
| tx_underrun_ev | input | 4 | Per-channel transmit underflow pulse |
| rx_full_ev | input | 4 | Per-channel receive full / almost-full pulse |
| rx_ovf_ev | input | 1 | Channel 0 receive overflow pulse |
| wcnt_done_ev | input | 1 | Word-count reached pulse |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, ones clear flags |
| rd_data | output | 32 | Read data, valid one cycle after the strobe |

## Verification
On every cycle the assertions check several things. They check that reserved bits never read as 1, that test mode mutes the read port, and that a disabled channel never gains a flag. They also check that the word-count flag obeys set, write-one-clear and set-over-clear, and that read data matches the flags of the previous edge. Only the bench's scenarios can show underflow qualification by an earlier load, because that depends on load history across enable changes. The same holds for the full field placement of every channel event and for selective clearing under varied write patterns.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int unsigned FIELDS_PER_CH = 4;

   typedef enum logic [1:0] {
      FLD_TX_EMPTY = 2'd0,
      FLD_TX_UNDER = 2'd1,
      FLD_RX_FULL  = 2'd2,
      FLD_RX_OVF   = 2'd3
   } irq_field_e;

   function automatic int unsigned flag_pos(input int unsigned ch, input irq_field_e f);
      return ch * FIELDS_PER_CH + int'(f);
   endfunction
endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else
         flag_o <= set_i | (flag_o & ~clr_i);
   end
endmodule

// File: rtl/spi_irq_chan.sv
module spi_irq_chan
   import spi_irq_pkg::*;
#(
   parameter bit HAS_OVF = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en_i,
   input  logic                     load_i,
   input  logic [FIELDS_PER_CH-1:0] ev_i,
   input  logic [FIELDS_PER_CH-1:0] clr_i,
   output logic [FIELDS_PER_CH-1:0] stat_o
);
   logic                     loaded_q;
   logic [FIELDS_PER_CH-1:0] set_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         loaded_q <= 1'b0;
      else if (!en_i)
         loaded_q <= 1'b0;
      else if (load_i)
         loaded_q <= 1'b1;
   end

   always_comb begin
      set_q               = ev_i & {FIELDS_PER_CH{en_i}};
      set_q[FLD_TX_UNDER] = set_q[FLD_TX_UNDER] & loaded_q;
   end

   for (genvar f = 0; f < FIELDS_PER_CH - 1; f++) begin : g_fld
      spi_irq_sticky u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_q[f]),
         .clr_i (clr_i[f]),
         .flag_o(stat_o[f])
      );
   end

   if (HAS_OVF) begin : g_ovf
      spi_irq_sticky u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_q[FLD_RX_OVF]),
         .clr_i (clr_i[FLD_RX_OVF]),
         .flag_o(stat_o[FLD_RX_OVF])
      );
   end else begin : g_rsvd
      logic unused_ovf;
      assign unused_ovf          = set_q[FLD_RX_OVF] ^ clr_i[FLD_RX_OVF];
      assign stat_o[FLD_RX_OVF]  = 1'b0;
   end
endmodule

// File: rtl/spi_irq_bus.sv
module spi_irq_bus #(
   parameter int unsigned          ADDR_W   = 8,
   parameter int unsigned          DATA_W   = 32,
   parameter logic [ADDR_W-1:0]    REG_ADDR = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_mode,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] status_i,
   output logic [DATA_W-1:0] clr_o,
   output logic [DATA_W-1:0] rd_data
);
   logic hit;

   assign hit   = (bus_addr == REG_ADDR);
   assign clr_o = (bus_wr && hit) ? bus_wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_data <= '0;
      else if (bus_rd && hit && !test_mode)
         rd_data <= status_i;
      else
         rd_data <= '0;
   end
endmodule

// File: rtl/spi_irq_status_reg.sv
module spi_irq_status_reg
   import spi_irq_pkg::*;
#(
   parameter int unsigned       NUM_CH   = 4,
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       EOW_BIT  = 17,
   parameter int unsigned       OVF_CH   = 0,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_mode,
   input  logic [NUM_CH-1:0] ch_enable,
   input  logic [NUM_CH-1:0] tx_load,
   input  logic [NUM_CH-1:0] tx_empty_ev,
   input  logic [NUM_CH-1:0] tx_underrun_ev,
   input  logic [NUM_CH-1:0] rx_full_ev,
   input  logic              rx_ovf_ev,
   input  logic              wcnt_done_ev,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned CH_BITS = FIELDS_PER_CH * NUM_CH;

   initial begin
      if (NUM_CH < 1 || CH_BITS > EOW_BIT || EOW_BIT >= DATA_W || OVF_CH >= NUM_CH)
         $fatal(1, "spi_irq_status_reg: inconsistent parameters");
   end

   logic [CH_BITS-1:0] ch_stat;
   logic               eow_q;
   logic [DATA_W-1:0]  status_q;
   logic [DATA_W-1:0]  clr_vec;
   logic               unused_clr;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [FIELDS_PER_CH-1:0] ev;
      if (c == OVF_CH) begin : g_ovf_src
         assign ev = {rx_ovf_ev, rx_full_ev[c], tx_underrun_ev[c], tx_empty_ev[c]};
      end else begin : g_no_ovf
         assign ev = {1'b0, rx_full_ev[c], tx_underrun_ev[c], tx_empty_ev[c]};
      end

      spi_irq_chan #(.HAS_OVF(c == OVF_CH)) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .en_i  (ch_enable[c]),
         .load_i(tx_load[c]),
         .ev_i  (ev),
         .clr_i (clr_vec[c*FIELDS_PER_CH +: FIELDS_PER_CH]),
         .stat_o(ch_stat[c*FIELDS_PER_CH +: FIELDS_PER_CH])
      );
   end

   spi_irq_sticky u_eow (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wcnt_done_ev),
      .clr_i (clr_vec[EOW_BIT]),
      .flag_o(eow_q)
   );

   always_comb begin
      status_q              = '0;
      status_q[CH_BITS-1:0] = ch_stat;
      status_q[EOW_BIT]     = eow_q;
   end

   assign unused_clr = ^clr_vec;

   spi_irq_bus #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .REG_ADDR(REG_ADDR)
   ) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .test_mode(test_mode),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_wdata(bus_wdata),
      .status_i (status_q),
      .clr_o    (clr_vec),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk #(
   parameter int unsigned       NUM_CH   = 4,
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       EOW_BIT  = 17,
   parameter int unsigned       OVF_CH   = 0,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              test_mode,
   input logic [NUM_CH-1:0] ch_enable,
   input logic [NUM_CH-1:0] tx_empty_ev,
   input logic              wcnt_done_ev,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] status
);
   function automatic logic [DATA_W-1:0] valid_mask();
      logic [DATA_W-1:0] m = '0;
      for (int c = 0; c < int'(NUM_CH); c++) m[c*4 +: 3] = 3'b111;
      m[OVF_CH*4 + 3] = 1'b1;
      m[EOW_BIT]      = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] VALID = valid_mask();

   logic hit;
   assign hit = (bus_addr == REG_ADDR);

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~VALID) == '0); // R2

   AST_TEST_MODE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |=> rd_data == '0); // R8

   AST_EOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt_done_ev |=> status[EOW_BIT]); // R7

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wcnt_done_ev && bus_wr && hit && bus_wdata[EOW_BIT]) |=> status[EOW_BIT]); // R4

   AST_W1C_EOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!wcnt_done_ev && bus_wr && hit && bus_wdata[EOW_BIT]) |=> !status[EOW_BIT]); // R3

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit && !test_mode) |=> rd_data == $past(status)); // R9

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && hit) |=> rd_data == '0); // R9

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      AST_IDLE_CH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_enable[c] |=> !$rose(status[c*4]) && !$rose(status[c*4+1])
                           && !$rose(status[c*4+2]) && !$rose(status[c*4+3])); // R5

      AST_TXE_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_enable[c] && tx_empty_ev[c]) |=> status[c*4]); // R5
   end
endmodule

bind spi_irq_status_reg spi_irq_status_chk #(
   .NUM_CH  (NUM_CH),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .EOW_BIT (EOW_BIT),
   .OVF_CH  (OVF_CH),
   .REG_ADDR(REG_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .test_mode   (test_mode),
   .ch_enable   (ch_enable),
   .tx_empty_ev (tx_empty_ev),
   .wcnt_done_ev(wcnt_done_ev),
   .bus_addr    (bus_addr),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_wdata   (bus_wdata),
   .rd_data     (rd_data),
   .status      (status_q)
);

// File: tb/spi_irq_status_reg_test.sv
module spi_irq_status_reg_test;
   localparam logic [7:0] RA = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        test_mode = 1'b0;
   logic [3:0]  ch_enable = '0, tx_load = '0, tx_empty_ev = '0, tx_underrun_ev = '0, rx_full_ev = '0;
   logic        rx_ovf_ev = 1'b0, wcnt_done_ev = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_data;

   int total = 0;
   int bad   = 0;
   logic [31:0] exp_q = '0;
   logic [3:0]  en_b = '0;
   logic [3:0]  loaded_b = '0;
   logic [31:0] valid_m;

   always #5 clk = ~clk;

   spi_irq_status_reg uut (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .ch_enable(ch_enable),
      .tx_load(tx_load), .tx_empty_ev(tx_empty_ev), .tx_underrun_ev(tx_underrun_ev),
      .rx_full_ev(rx_full_ev), .rx_ovf_ev(rx_ovf_ev), .wcnt_done_ev(wcnt_done_ev),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0; v = rd_data;
   endtask

   task automatic rd_check(input string req);
      logic [31:0] v;
      rd_reg(RA, v);
      check(req, v, exp_q);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
      if (a == RA) exp_q = exp_q & ~d;
   endtask

   task automatic set_en(input logic [3:0] m);
      @(negedge clk); ch_enable = m;
      @(negedge clk);
      en_b = m; loaded_b = loaded_b & m;
   endtask

   task automatic load(input int c);
      @(negedge clk); tx_load[c] = 1'b1;
      @(negedge clk); tx_load[c] = 1'b0;
      if (en_b[c]) loaded_b[c] = 1'b1;
   endtask

   // kind: 0 empty, 1 underflow, 2 full, 3 overflow (channel 0 only)
   task automatic drive_ev(input int c, input int kind, input logic v);
      case (kind)
         0: tx_empty_ev[c]    = v;
         1: tx_underrun_ev[c] = v;
         2: rx_full_ev[c]     = v;
         default: if (c == 0) rx_ovf_ev = v;
      endcase
   endtask

   task automatic model_ev(input int c, input int kind);
      if (en_b[c] && (kind != 1 || loaded_b[c]) && (kind != 3 || c == 0))
         exp_q[4*c + kind] = 1'b1;
   endtask

   task automatic pulse(input int c, input int kind);
      @(negedge clk); drive_ev(c, kind, 1'b1);
      @(negedge clk); drive_ev(c, kind, 1'b0);
      model_ev(c, kind);
   endtask

   initial begin
      logic [31:0] v;
      valid_m = 32'h0002_0008;
      for (int c = 0; c < 4; c++) valid_m = valid_m | (32'h7 << (4*c));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_check("R1 reset value");

      // Field sweep, channels enabled but never loaded: underflow suppressed
      set_en(4'hF);
      for (int c = 0; c < 4; c++)
         for (int k = 0; k < 4; k++) begin
            pulse(c, k);
            rd_check($sformatf("R2 R6 unloaded ch%0d kind%0d", c, k));
         end
      wr_reg(RA, 32'hFFFF_FFFF);
      rd_check("R3 clear all");

      // After a load, underflow is recorded
      for (int c = 0; c < 4; c++) load(c);
      for (int c = 0; c < 4; c++) begin
         pulse(c, 1);
         rd_check($sformatf("R6 loaded underflow ch%0d", c));
      end
      wr_reg(RA, 32'hFFFF_FFFF);

      // Disabled channel ignores everything; re-enable drops the load history
      set_en(4'b1011);
      for (int k = 0; k < 4; k++) pulse(2, k);
      pulse(0, 3);
      rd_check("R5 disabled ch2 quiet, ch0 overflow set");
      set_en(4'hF);
      pulse(2, 1);
      rd_check("R6 underflow after re-enable suppressed");
      @(negedge clk); tx_load[2] = 1'b1; tx_underrun_ev[2] = 1'b1;
      @(negedge clk); tx_load[2] = 1'b0; tx_underrun_ev[2] = 1'b0;
      loaded_b[2] = 1'b1;
      rd_check("R6 same-cycle load does not qualify");
      pulse(2, 1);
      rd_check("R6 underflow after earlier load");

      // Selective write-one-to-clear under several patterns
      for (int p = 0; p < 6; p++) begin
         for (int c = 0; c < 4; c++) for (int k = 0; k < 4; k++) pulse(c, k);
         @(negedge clk); wcnt_done_ev = 1'b1;
         @(negedge clk); wcnt_done_ev = 1'b0; exp_q[17] = 1'b1;
         rd_reg(RA, v);
         check("R2 reserved bits read zero", v & ~valid_m, 32'h0);
         check("R2 all defined flags set", v, valid_m);
         wr_reg(RA, 32'h0);
         rd_check("R3 zero write keeps flags");
         wr_reg(RA, (32'h9E37_79B9 * (p + 1)) ^ (32'h1 << (p * 3)));
         rd_check($sformatf("R3 selective clear pattern %0d", p));
         wr_reg(RA, 32'hFFFF_FFFF);
      end

      // Set wins over a same-cycle clear
      @(negedge clk); bus_addr = RA; bus_wr = 1'b1; bus_wdata = 32'hFFFF_FFFF;
      wcnt_done_ev = 1'b1; tx_empty_ev[1] = 1'b1;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0; wcnt_done_ev = 1'b0; tx_empty_ev[1] = 1'b0;
      exp_q = 32'h0002_0010;
      rd_check("R4 set beats clear");
      wr_reg(RA, 32'hFFFF_FFFF);

      // Word count event with all channels off
      set_en(4'h0);
      @(negedge clk); wcnt_done_ev = 1'b1;
      @(negedge clk); wcnt_done_ev = 1'b0; exp_q[17] = 1'b1;
      rd_check("R7 word count with channels off");
      wr_reg(RA, 32'h0002_0000);
      rd_check("R7 word count cleared");

      // Test mode masks reads but state persists
      set_en(4'hF);
      @(negedge clk); test_mode = 1'b1;
      pulse(3, 2);
      rd_reg(RA, v);
      check("R8 test mode reads zero", v, 32'h0);
      @(negedge clk); test_mode = 1'b0;
      rd_check("R8 flag visible after test mode");

      // Other addresses: read zero, write clears nothing
      rd_reg(8'h1C, v);
      check("R9 foreign address read", v, 32'h0);
      wr_reg(8'h1C, 32'hFFFF_FFFF);
      rd_check("R9 foreign write no clear");
      @(negedge clk);
      check("R9 idle rd_data zero", rd_data, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule